// File: doc/BRIEF.md
# UART Modem Control and Loopback Channel

This block is the modem-signal slice of one channel of a 16550-style UART. It holds the control state for the request-to-send line and for the local loopback path. It also keeps a small status register that watches the ring-indicator input. A host reaches it through a byte-wide register port with an address, a write strobe and a read strobe. The serializer and deserializer of the channel connect to it on one side, and the package pins connect on the other.

The ring-indicator input is active low and asynchronous. It passes through a synchronizer. When the line returns from low to high, the block records the event in a sticky change flag. That flag raises the modem-status interrupt request if the host has enabled the interrupt. Reading the status register clears the flag.

The request-to-send pin is active low. Software controls it through a control bit. When the automatic flow-control enable is set, a fill-level hint from the receive side can also force it inactive. In loopback the block holds the transmit pin at the idle mark level and ignores the receive pin. The serializer output is then fed straight back to the deserializer.

Top module: `uart_modem_ctl`

## Requirements
- R1: While reset is high and after it is released, the block is cleared. `rts_n` is 1, `msint` is 0, and the control, enable and feature registers read 0x00.
- R2: Register map: address 0 is the interrupt-enable register (bit 3 = modem-status interrupt enable). Address 1 is modem control (bit 1 = RTS request, bit 4 = loopback). Address 2 is modem status, which is read-only (bit 2 = ring trailing-edge flag, bit 6 = ring active level). Address 3 is the feature register (bit 6 = auto-RTS enable). Writing 1 to control bit 1 drives `rts_n` to 0 in the cycle after the write, and writing 0 returns it to 1.
- R3: When the auto-RTS enable (feature bit 6) is 1 and `rx_fill_high` is 1, `rts_n` is 1 whatever the RTS request is. When that enable is 0, `rx_fill_high` has no effect on `rts_n`.
- R4: A low-to-high transition on `ri_n` sets status bit 2 within SYNC_STAGES+1 clock edges. A high-to-low transition does not set it.
- R5: Status bit 6 reads 1 while the synchronized `ri_n` is low and 0 while it is high.
- R6: A read of the status register clears bit 2 after the read. If a new trailing edge is detected in the same cycle as the read, the flag stays set.
- R7: `msint` is 1 exactly when the change flag is set and interrupt-enable bit 3 is 1. Clearing the enable hides the request but does not clear the flag.
- R8: With loopback set, `tx_pin` is held at 1 and `ser_rx_out` follows `ser_tx_in`. `rx_pin` has no effect.
- R9: With loopback clear, `tx_pin` follows `ser_tx_in` and `ser_rx_out` follows `rx_pin`.
- R10: While reset is high, `tx_pin` and `ser_rx_out` are both held at 1, whatever the serial inputs are.
- R11: Writes to the status register are ignored. Register bits with no defined function read 0, and addresses 4 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, used for read side effects |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ser_tx_in | input | 1 | Bit stream from the channel serializer |
| ser_rx_out | output | 1 | Bit stream to the channel deserializer |
| tx_pin | output | 1 | Serial transmit pin |
| rx_pin | input | 1 | Serial receive pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| rx_fill_high | input | 1 | Receive side at its flow-control threshold |
| ri_n | input | 1 | Ring-indicator pin, active low, asynchronous |
| msint | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a status read that lands in the same cycle in which the synchronizer reports a new trailing edge on the ring input. The rule there is that the set must win over the clear. The bench releases `ri_n` on a falling clock edge and counts the two synchronizer flops. It then places the read strobe exactly in the cycle where the edge becomes visible. A follow-up read must still show the flag. The bench also confirms that a falling ring edge sets nothing, and that masking the interrupt keeps the flag intact.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_IEN   = 3'd0,
        ADDR_MCTL  = 3'd1,
        ADDR_MSTAT = 3'd2,
        ADDR_EFEAT = 3'd3
    } reg_addr_e;

    localparam int unsigned IEN_MS_BIT     = 3;
    localparam int unsigned MCTL_RTS_BIT   = 1;
    localparam int unsigned MCTL_LOOP_BIT  = 4;
    localparam int unsigned MSTAT_CHG_BIT  = 2;
    localparam int unsigned MSTAT_LVL_BIT  = 6;
    localparam int unsigned EFEAT_ARTS_BIT = 6;

    typedef struct packed {
        logic ms_en;
        logic rts_req;
        logic loop_en;
        logic auto_rts;
    } ctl_state_t;

    typedef struct packed {
        logic ring_active;
        logic ring_trail;
    } ring_state_t;

    function automatic logic [DATA_W-1:0] pack_ien(input ctl_state_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[IEN_MS_BIT] = c.ms_en;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mctl(input ctl_state_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[MCTL_RTS_BIT]  = c.rts_req;
        v[MCTL_LOOP_BIT] = c.loop_en;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_efeat(input ctl_state_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EFEAT_ARTS_BIT] = c.auto_rts;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mstat(input ring_state_t r);
        logic [DATA_W-1:0] v;
        v = '0;
        v[MSTAT_CHG_BIT] = r.ring_trail;
        v[MSTAT_LVL_BIT] = r.ring_active;
        return v;
    endfunction

endpackage

// File: rtl/mctl_regfile.sv
module mctl_regfile
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_state_t        ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_IEN:   ctl.ms_en <= wr_data[IEN_MS_BIT];
                ADDR_MCTL: begin
                    ctl.rts_req <= wr_data[MCTL_RTS_BIT];
                    ctl.loop_en <= wr_data[MCTL_LOOP_BIT];
                end
                ADDR_EFEAT: ctl.auto_rts <= wr_data[EFEAT_ARTS_BIT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ring_monitor.sv
module ring_monitor #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ri_n,
    input  logic clr_req,
    output logic ring_active,
    output logic rise_evt,
    output logic chg_flag
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= ri_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], ri_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[LAST];
    end

    assign ring_active = ~sync_q[LAST];
    assign rise_evt    = sync_q[LAST] & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst)          chg_flag <= 1'b0;
        else if (rise_evt) chg_flag <= 1'b1;
        else if (clr_req) chg_flag <= 1'b0;
    end

endmodule

// File: rtl/serial_path.sv
module serial_path (
    input  logic rst,
    input  logic loop_en,
    input  logic ser_tx_in,
    input  logic rx_pin,
    output logic tx_pin,
    output logic ser_rx_out
);

    always_comb begin
        if (rst) begin
            tx_pin     = 1'b1;
            ser_rx_out = 1'b1;
        end else if (loop_en) begin
            tx_pin     = 1'b1;
            ser_rx_out = ser_tx_in;
        end else begin
            tx_pin     = ser_tx_in;
            ser_rx_out = rx_pin;
        end
    end

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ser_tx_in,
    output logic              ser_rx_out,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              rts_n,
    input  logic              rx_fill_high,
    input  logic              ri_n,
    output logic              msint
);

    ctl_state_t  ctl;
    ring_state_t ring;
    logic        ri_rise;
    logic        stat_rd;

    assign stat_rd = reg_rd && (reg_addr == ADDR_MSTAT);

    mctl_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .ctl     (ctl)
    );

    ring_monitor #(.STAGES(SYNC_STAGES)) u_ring (
        .clk         (clk),
        .rst         (rst),
        .ri_n        (ri_n),
        .clr_req     (stat_rd),
        .ring_active (ring.ring_active),
        .rise_evt    (ri_rise),
        .chg_flag    (ring.ring_trail)
    );

    serial_path u_ser (
        .rst        (rst),
        .loop_en    (ctl.loop_en),
        .ser_tx_in  (ser_tx_in),
        .rx_pin     (rx_pin),
        .tx_pin     (tx_pin),
        .ser_rx_out (ser_rx_out)
    );

    assign rts_n = ~(ctl.rts_req & ~(ctl.auto_rts & rx_fill_high));
    assign msint = ctl.ms_en & ring.ring_trail;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            ADDR_IEN:   reg_rdata = pack_ien(ctl);
            ADDR_MCTL:  reg_rdata = pack_mctl(ctl);
            ADDR_MSTAT: reg_rdata = pack_mstat(ring);
            ADDR_EFEAT: reg_rdata = pack_efeat(ctl);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk
    import uart_modem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              ser_tx_in,
    input logic              ser_rx_out,
    input logic              tx_pin,
    input logic              rts_n,
    input logic              rx_fill_high,
    input logic              msint,
    input logic              auto_rts,
    input logic              loop_en,
    input logic              ri_rise,
    input logic              ri_chg
);

    a_r2_rts_from_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_MCTL && !auto_rts)
        |=> (rts_n == !$past(reg_wdata[MCTL_RTS_BIT])));

    a_r3_auto_rts_holds_off: assert property (@(posedge clk) disable iff (rst)
        (auto_rts && rx_fill_high) |-> rts_n);

    a_r4_flag_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ri_chg) |-> $past(ri_rise));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_MSTAT && !ri_rise) |=> !ri_chg);

    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(msint) |-> ($past(ri_rise) ||
                          $past(reg_wr && reg_addr == ADDR_IEN && reg_wdata[IEN_MS_BIT])));

    a_r8_tx_idle_in_loop: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (tx_pin && ser_rx_out == ser_tx_in));

    always @(posedge clk) begin
        if (rst) begin
            a_r10_pins_idle_in_reset: assert (tx_pin && ser_rx_out);
        end
    end

endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .ser_tx_in    (ser_tx_in),
    .ser_rx_out   (ser_rx_out),
    .tx_pin       (tx_pin),
    .rts_n        (rts_n),
    .rx_fill_high (rx_fill_high),
    .msint        (msint),
    .auto_rts     (ctl.auto_rts),
    .loop_en      (ctl.loop_en),
    .ri_rise      (ri_rise),
    .ri_chg       (ring.ring_trail)
);

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       ser_tx_in = 1'b1;
    logic       ser_rx_out;
    logic       tx_pin;
    logic       rx_pin = 1'b1;
    logic       rts_n;
    logic       rx_fill_high = 1'b0;
    logic       ri_n = 1'b1;
    logic       msint;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    uart_modem_ctl u_uart_modem_ctl (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .ser_tx_in    (ser_tx_in),
        .ser_rx_out   (ser_rx_out),
        .tx_pin       (tx_pin),
        .rx_pin       (rx_pin),
        .rts_n        (rts_n),
        .rx_fill_high (rx_fill_high),
        .ri_n         (ri_n),
        .msint        (msint)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        check("R1 rts_n after reset", {7'd0, rts_n}, 8'h01);
        check("R1 msint after reset", {7'd0, msint}, 8'h00);
        rd(3'd0, d); check("R1 ien reset", d, 8'h00);
        rd(3'd1, d); check("R1 mctl reset", d, 8'h00);
        rd(3'd3, d); check("R1 efeat reset", d, 8'h00);
    endtask

    task automatic t_rts_manual();
        wr(3'd1, 8'h02);
        check("R2 rts_n asserted", {7'd0, rts_n}, 8'h00);
        wr(3'd1, 8'h00);
        check("R2 rts_n released", {7'd0, rts_n}, 8'h01);
    endtask

    task automatic t_auto_rts();
        wr(3'd1, 8'h02);
        rx_fill_high = 1'b1;
        #1 check("R3 fill hint ignored without auto", {7'd0, rts_n}, 8'h00);
        wr(3'd3, 8'h40);
        check("R3 auto holds rts off", {7'd0, rts_n}, 8'h01);
        rx_fill_high = 1'b0;
        #1 check("R3 auto released", {7'd0, rts_n}, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_ring_edges();
        logic [7:0] d;
        ri_n = 1'b0;
        wait_cycles(4);
        rd(3'd2, d);
        check("R4 R5 falling ring edge: level only", d, 8'h40);
        ri_n = 1'b1;
        wait_cycles(4);
        rd(3'd2, d);
        check("R4 trailing edge sets flag", d, 8'h04);
        rd(3'd2, d);
        check("R6 read cleared flag", d, 8'h00);
    endtask

    task automatic t_irq_mask();
        logic [7:0] d;
        wr(3'd0, 8'h08);
        check("R7 no request without flag", {7'd0, msint}, 8'h00);
        ri_n = 1'b0; wait_cycles(4);
        ri_n = 1'b1; wait_cycles(4);
        check("R7 request raised", {7'd0, msint}, 8'h01);
        wr(3'd0, 8'h00);
        check("R7 request masked", {7'd0, msint}, 8'h00);
        wr(3'd0, 8'h08);
        check("R7 flag survived mask", {7'd0, msint}, 8'h01);
        rd(3'd2, d);
        check("R6 R7 read drops request", {7'd0, msint}, 8'h00);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_read_edge_collision();
        logic [7:0] d;
        ri_n = 1'b0; wait_cycles(4);
        ri_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 3'd2; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        rd(3'd2, d);
        check("R6 set wins over coincident read", d, 8'h04);
        rd(3'd2, d);
        check("R6 flag cleared afterwards", d, 8'h00);
    endtask

    task automatic t_loopback();
        wr(3'd1, 8'h10);
        ser_tx_in = 1'b0; rx_pin = 1'b1;
        #1;
        check("R8 tx pin idle in loop", {7'd0, tx_pin}, 8'h01);
        check("R8 loop data low", {7'd0, ser_rx_out}, 8'h00);
        ser_tx_in = 1'b1; rx_pin = 1'b0;
        #1;
        check("R8 rx pin ignored in loop", {7'd0, ser_rx_out}, 8'h01);
        wr(3'd1, 8'h00);
        ser_tx_in = 1'b0; rx_pin = 1'b1;
        #1;
        check("R9 tx pin follows serializer", {7'd0, tx_pin}, 8'h00);
        check("R9 rx pin to deserializer", {7'd0, ser_rx_out}, 8'h01);
        rx_pin = 1'b0;
        #1 check("R9 rx pin low passes", {7'd0, ser_rx_out}, 8'h00);
        ser_tx_in = 1'b1; rx_pin = 1'b1;
    endtask

    task automatic t_ignored_writes();
        logic [7:0] d;
        wr(3'd2, 8'hFF);
        rd(3'd2, d); check("R11 status write ignored", d, 8'h00);
        check("R11 no request from status write", {7'd0, msint}, 8'h00);
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R11 ien unused bits", d, 8'h08);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); check("R11 mctl unused bits", d, 8'h12);
        wr(3'd3, 8'hFF);
        rd(3'd3, d); check("R11 efeat unused bits", d, 8'h40);
        rd(3'd5, d); check("R11 unmapped address", d, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_reset_mid_run();
        logic [7:0] d;
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h08);
        ser_tx_in = 1'b0; rx_pin = 1'b0;
        @(negedge clk); rst = 1'b1;
        #1;
        check("R10 tx pin held in reset", {7'd0, tx_pin}, 8'h01);
        check("R10 rx path held in reset", {7'd0, ser_rx_out}, 8'h01);
        @(negedge clk);
        check("R1 rts_n cleared by reset", {7'd0, rts_n}, 8'h01);
        rst = 1'b0;
        ser_tx_in = 1'b1; rx_pin = 1'b1;
        rd(3'd1, d); check("R1 mctl cleared by reset", d, 8'h00);
        rd(3'd0, d); check("R1 ien cleared by reset", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R10 pins idle during power-on reset", {6'd0, tx_pin, ser_rx_out}, 8'h03);
        rst = 1'b0;
        t_reset_state();
        t_rts_manual();
        t_auto_rts();
        t_ring_edges();
        t_irq_mask();
        t_read_edge_collision();
        t_loopback();
        t_ignored_writes();
        t_reset_mid_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule